// File: doc/BRIEF.md
# NAND Flash Bring-Up Sequencer

This block runs exactly once after reset to bring a single attached NAND flash device into a known, described state. It captures four strap inputs at reset release. It waits for the device to report ready and probes for an ONFI signature. Depending on the answer, it reads either the parameter page or the legacy ID bytes, and it records the device geometry and bus width. It then optionally preloads block 0 / page 0 so that boot code can be fetched directly. It finishes with a device reset and a sticky completion flag.

Toward the device the block emits a stream of command and address bytes on a valid/ready channel. A byte is transferred on each cycle where `op_valid` and `op_ready` are both high. While `op_ready` is low the sequencer holds `op_valid`, `op_is_addr` and `op_byte` unchanged. Data read from the device returns on a second valid/ready channel. The block raises `rd_ready` only in the cycles where it expects a read byte, and the PHY may insert gaps by holding `rd_valid` low. The ready/busy line, the wait limit and all results are plain level signals.

Top module: `nand_bringup_seq`

## Requirements
- R1: The four straps are captured on the first clock edge after `rst_n` rises. Changes to them afterwards have no effect on the op sequence or on the results.
- R2: With the no-init strap set, the only op issued is command 0xFF. After the busy wait that follows it, `rst_done` rises. `page_bytes`, `pages_per_block`, `maker_id`, `device_id`, `bus16` and `is_onfi` keep their reset value 0.
- R3: Without no-init, and unless the small-page strap is set, the block first waits for `dev_ready` high. It then issues command 0x90, address 0x20, and reads 4 bytes. The bytes 0x4F 0x4E 0x46 0x49 in that order select the ONFI path. That path issues command 0xEC and address 0x00, waits busy, then reads PP_LEN (96) bytes. From those bytes: `bus16` = bit 0 of byte 6, `maker_id` = byte 64, `page_bytes` = bytes 80..83 little-endian, `pages_per_block` = bytes 92..95 little-endian, `is_onfi` = 1.
- R4: A signature mismatch selects the legacy path. It issues command 0xFF and waits busy, then issues command 0x90 and address 0x00 and reads ID bytes b0..b3. Results: `maker_id` = b0, `device_id` = b1, `page_bytes` = 1024 << b3[1:0], `pages_per_block` = (64 << b3[5:4]) >> b3[1:0], `bus16` = b3[6], `is_onfi` = 0.
- R5: The small-page strap skips the ONFI probe and goes straight to the legacy path. Maker and device are still captured from b0 and b1. The geometry is forced to 512-byte pages and 32 pages per block, with `bus16` = 0.
- R6: After discovery the block issues command 0xFF and waits busy. The width result is committed to `bus16` at that point.
- R7: Unless the no-preload strap is set, the block then issues command 0x00, two column address bytes 0x00, and row address bytes 0x00. There are 2 row bytes when the two-row strap is 1 and 3 when it is 0. Command 0x30 follows, then a busy wait.
- R8: Last, the block issues command 0xFF and waits busy. It then sets `rst_done`, which stays set until reset.
- R9: Each busy wait needs `dev_ready` to fall and then rise again. The initial wait needs only `dev_ready` high. No op is issued while the device is busy.
- R10: If a wait lasts `wait_limit` cycles without completing, `wait_timeout` sets and stays set. No further op is issued, and `rst_done` stays 0.
- R11: Under back-pressure an offered op stays stable until it is accepted. `rd_ready` is high only while a read byte is expected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| strap_noinit | input | 1 | Skip discovery, only reset the device |
| strap_small_page | input | 1 | Force legacy 512-byte-page handling |
| strap_no_preload | input | 1 | Skip block 0 / page 0 load |
| strap_two_row | input | 1 | 1: two row address bytes, 0: three |
| dev_ready | input | 1 | Device ready (1) / busy (0) |
| wait_limit | input | TW (16) | Cycle limit for any wait |
| op_valid | output | 1 | Op byte offered |
| op_ready | input | 1 | PHY accepts op byte |
| op_is_addr | output | 1 | 1: address byte, 0: command byte |
| op_byte | output | 8 | Command or address value |
| rd_valid | input | 1 | Read byte present |
| rd_ready | output | 1 | Sequencer expects a read byte |
| rd_data | input | 8 | Read byte |
| is_onfi | output | 1 | ONFI signature matched |
| bus16 | output | 1 | Device bus is 16 bits |
| page_bytes | output | 32 | Main page size in bytes |
| pages_per_block | output | 32 | Pages per erase block |
| maker_id | output | 8 | Manufacturer code |
| device_id | output | 8 | Device code (legacy path) |
| rst_done | output | 1 | Sticky bring-up complete |
| wait_timeout | output | 1 | Sticky wait timeout error |

## Verification
Op bytes carry no fixed latency: each one is due in order, one per accepted handshake. A scoreboard fed ahead of time with the expected order compares each op when the bench sees `op_valid` and `op_ready` high between edges, that is, in the cycle before the transfer edge. The captured results are due once `rst_done` rises. The timeout flag is due no earlier than `wait_limit` cycles after release. The bench polls `rst_done` and `wait_timeout` at falling edges, checks the results only after one of them is seen, and then keeps watching for several more cycles to catch any stray op.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
  typedef enum logic [4:0] {
    S_STRAP, S_WAITRDY, S_ID_CMD, S_ID_ADR, S_ID_RD, S_ID_CHK,
    S_PP_CMD, S_PP_ADR, S_PP_BSY, S_PP_RD,
    S_LG_RST, S_LG_BSY, S_LG_CMD, S_LG_ADR, S_LG_RD,
    S_WR_RST, S_WR_BSY, S_PL_CMD, S_PL_ADR, S_PL_CMD2, S_PL_BSY,
    S_FR_RST, S_FR_BSY, S_DONE, S_ERR
  } seq_state_t;

  typedef enum logic [1:0] {CAP_NONE, CAP_SIG, CAP_PARAM, CAP_LEGACY} cap_src_t;

  localparam logic [7:0] OPC_RESET   = 8'hFF;
  localparam logic [7:0] OPC_READID  = 8'h90;
  localparam logic [7:0] OPC_PARAM   = 8'hEC;
  localparam logic [7:0] OPC_READ1   = 8'h00;
  localparam logic [7:0] OPC_READ2   = 8'h30;
  localparam logic [7:0] ADR_ONFI_ID = 8'h20;
endpackage

// File: rtl/nbs_busy_wait.sv
module nbs_busy_wait #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          skip_low,
  input  logic          dev_ready,
  input  logic [TW-1:0] limit,
  output logic          done,
  output logic          tmo
);
  typedef enum logic [1:0] {BW_IDLE, BW_LOW, BW_HIGH} bw_phase_t;
  bw_phase_t     phase;
  logic [TW-1:0] cnt;

  assign done = (phase == BW_HIGH) && dev_ready;
  assign tmo  = (phase != BW_IDLE) && !done && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= BW_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        BW_IDLE: if (en) begin
          phase <= skip_low ? BW_HIGH : BW_LOW;
          cnt   <= '0;
        end
        BW_LOW: if (tmo) phase <= BW_IDLE;
          else begin
            cnt <= cnt + 1'b1;
            if (!dev_ready) phase <= BW_HIGH;
          end
        BW_HIGH: if (done || tmo) phase <= BW_IDLE;
          else cnt <= cnt + 1'b1;
        default: phase <= BW_IDLE;
      endcase
    end
  end

  // R9
  wait_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == BW_LOW && dev_ready && !tmo) |=> (phase == BW_LOW));
endmodule

// File: rtl/nbs_capture.sv
module nbs_capture #(
  parameter int IDXW = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  nbs_pkg::cap_src_t     src,
  input  logic                  vld,
  input  logic [IDXW-1:0]       idx,
  input  logic [7:0]            data,
  input  logic                  small_page,
  output logic                  sig_ok,
  output logic                  bus16_raw,
  output logic [31:0]           page_bytes,
  output logic [31:0]           ppb,
  output logic [7:0]            maker,
  output logic [7:0]            device
);
  import nbs_pkg::*;

  localparam int WORD_PAGE = 80 / 4;
  localparam int WORD_PPB  = 92 / 4;
  localparam int OFS_FEAT  = 6;
  localparam int OFS_MAKER = 64;

  logic [4:0] lane_sh;
  logic [7:0] sig_exp;
  assign lane_sh = {idx[1:0], 3'b000};

  always_comb begin
    case (idx[1:0])
      2'd0:    sig_exp = 8'h4F;
      2'd1:    sig_exp = 8'h4E;
      2'd2:    sig_exp = 8'h46;
      default: sig_exp = 8'h49;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_ok     <= 1'b0;
      bus16_raw  <= 1'b0;
      page_bytes <= '0;
      ppb        <= '0;
      maker      <= '0;
      device     <= '0;
    end else if (vld) begin
      case (src)
        CAP_SIG:
          sig_ok <= (data == sig_exp) && ((idx == '0) || sig_ok);
        CAP_PARAM: begin
          if (idx == IDXW'(OFS_FEAT))  bus16_raw <= data[0];
          if (idx == IDXW'(OFS_MAKER)) maker     <= data;
          if (idx[IDXW-1:2] == (IDXW-2)'(WORD_PAGE)) page_bytes[lane_sh +: 8] <= data;
          if (idx[IDXW-1:2] == (IDXW-2)'(WORD_PPB))  ppb[lane_sh +: 8]        <= data;
        end
        CAP_LEGACY: begin
          if (idx == IDXW'(0)) maker  <= data;
          if (idx == IDXW'(1)) device <= data;
          if (idx == IDXW'(3)) begin
            if (small_page) begin
              page_bytes <= 32'd512;
              ppb        <= 32'd32;
              bus16_raw  <= 1'b0;
            end else begin
              page_bytes <= 32'd1024 << data[1:0];
              ppb        <= (32'd64 << data[5:4]) >> data[1:0];
              bus16_raw  <= data[6];
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nand_bringup_seq.sv
module nand_bringup_seq #(
  parameter int PP_LEN = 96,
  parameter int TW     = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap_noinit,
  input  logic          strap_small_page,
  input  logic          strap_no_preload,
  input  logic          strap_two_row,
  input  logic          dev_ready,
  input  logic [TW-1:0] wait_limit,
  output logic          op_valid,
  input  logic          op_ready,
  output logic          op_is_addr,
  output logic [7:0]    op_byte,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [7:0]    rd_data,
  output logic          is_onfi,
  output logic          bus16,
  output logic [31:0]   page_bytes,
  output logic [31:0]   pages_per_block,
  output logic [7:0]    maker_id,
  output logic [7:0]    device_id,
  output logic          rst_done,
  output logic          wait_timeout
);
  import nbs_pkg::*;

  localparam int IDXW = $clog2(PP_LEN);
  localparam logic [IDXW-1:0] PP_LAST = IDXW'(PP_LEN - 1);
  localparam logic [IDXW-1:0] ID_LAST = IDXW'(3);

  seq_state_t      state;
  logic [IDXW-1:0] cnt;
  logic [3:0]      straps_q;
  logic            bw_en, bw_done, bw_tmo, sig_ok, bus16_raw, rd_fire;
  logic [IDXW-1:0] pl_last;
  cap_src_t        cap_src;

  wire noinit_q = straps_q[3];
  wire small_q  = straps_q[2];
  wire noload_q = straps_q[1];
  wire tworow_q = straps_q[0];

  assign pl_last = tworow_q ? IDXW'(3) : IDXW'(4);
  assign rd_fire = rd_valid && rd_ready;

  always_comb begin
    op_valid   = 1'b1;
    op_is_addr = 1'b0;
    op_byte    = 8'h00;
    case (state)
      S_ID_CMD, S_LG_CMD:             op_byte = OPC_READID;
      S_ID_ADR: begin op_is_addr = 1'b1; op_byte = ADR_ONFI_ID; end
      S_PP_CMD:                       op_byte = OPC_PARAM;
      S_PP_ADR, S_LG_ADR, S_PL_ADR:   op_is_addr = 1'b1;
      S_LG_RST, S_WR_RST, S_FR_RST:   op_byte = OPC_RESET;
      S_PL_CMD:                       op_byte = OPC_READ1;
      S_PL_CMD2:                      op_byte = OPC_READ2;
      default:                        op_valid = 1'b0;
    endcase
  end

  always_comb begin
    rd_ready = 1'b1;
    case (state)
      S_ID_RD: cap_src = CAP_SIG;
      S_PP_RD: cap_src = CAP_PARAM;
      S_LG_RD: cap_src = CAP_LEGACY;
      default: begin cap_src = CAP_NONE; rd_ready = 1'b0; end
    endcase
  end

  assign bw_en = (state == S_WAITRDY) || (state == S_PP_BSY) || (state == S_LG_BSY) ||
                 (state == S_WR_BSY) || (state == S_PL_BSY) || (state == S_FR_BSY);

  nbs_busy_wait #(.TW(TW)) u_wait (
    .clk(clk), .rst_n(rst_n), .en(bw_en), .skip_low(state == S_WAITRDY),
    .dev_ready(dev_ready), .limit(wait_limit), .done(bw_done), .tmo(bw_tmo)
  );

  nbs_capture #(.IDXW(IDXW)) u_cap (
    .clk(clk), .rst_n(rst_n), .src(cap_src), .vld(rd_fire), .idx(cnt),
    .data(rd_data), .small_page(small_q), .sig_ok(sig_ok), .bus16_raw(bus16_raw),
    .page_bytes(page_bytes), .ppb(pages_per_block), .maker(maker_id), .device(device_id)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_STRAP;
      cnt          <= '0;
      straps_q     <= '0;
      is_onfi      <= 1'b0;
      bus16        <= 1'b0;
      rst_done     <= 1'b0;
      wait_timeout <= 1'b0;
    end else begin
      if (bw_en && bw_tmo) begin
        state <= S_ERR;
      end else begin
        case (state)
          S_STRAP: begin
            straps_q <= {strap_noinit, strap_small_page, strap_no_preload, strap_two_row};
            state    <= strap_noinit ? S_FR_RST : S_WAITRDY;
          end
          S_WAITRDY: if (bw_done) state <= small_q ? S_LG_RST : S_ID_CMD;
          S_ID_CMD:  if (op_ready) state <= S_ID_ADR;
          S_ID_ADR:  if (op_ready) begin state <= S_ID_RD; cnt <= '0; end
          S_ID_RD:   if (rd_fire) begin
            cnt <= cnt + 1'b1;
            if (cnt == ID_LAST) state <= S_ID_CHK;
          end
          S_ID_CHK: begin
            is_onfi <= sig_ok;
            state   <= sig_ok ? S_PP_CMD : S_LG_RST;
          end
          S_PP_CMD:  if (op_ready) state <= S_PP_ADR;
          S_PP_ADR:  if (op_ready) state <= S_PP_BSY;
          S_PP_BSY:  if (bw_done) begin state <= S_PP_RD; cnt <= '0; end
          S_PP_RD:   if (rd_fire) begin
            cnt <= cnt + 1'b1;
            if (cnt == PP_LAST) state <= S_WR_RST;
          end
          S_LG_RST:  if (op_ready) state <= S_LG_BSY;
          S_LG_BSY:  if (bw_done) state <= S_LG_CMD;
          S_LG_CMD:  if (op_ready) state <= S_LG_ADR;
          S_LG_ADR:  if (op_ready) begin state <= S_LG_RD; cnt <= '0; end
          S_LG_RD:   if (rd_fire) begin
            cnt <= cnt + 1'b1;
            if (cnt == ID_LAST) state <= S_WR_RST;
          end
          S_WR_RST:  if (op_ready) state <= S_WR_BSY;
          S_WR_BSY:  if (bw_done) begin
            bus16 <= bus16_raw;
            state <= noload_q ? S_FR_RST : S_PL_CMD;
          end
          S_PL_CMD:  if (op_ready) begin state <= S_PL_ADR; cnt <= '0; end
          S_PL_ADR:  if (op_ready) begin
            cnt <= cnt + 1'b1;
            if (cnt == pl_last) state <= S_PL_CMD2;
          end
          S_PL_CMD2: if (op_ready) state <= S_PL_BSY;
          S_PL_BSY:  if (bw_done) state <= S_FR_RST;
          S_FR_RST:  if (op_ready) state <= S_FR_BSY;
          S_FR_BSY:  if (bw_done) begin state <= S_DONE; rst_done <= 1'b1; end
          S_DONE:    state <= S_DONE;
          S_ERR:     wait_timeout <= 1'b1;
          default:   state <= S_ERR;
        endcase
      end
    end
  end

  // R1
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_STRAP) |=> $stable(straps_q));
  // R11
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_ready) |=> (op_valid && $stable(op_byte) && $stable(op_is_addr)));
  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_done |=> rst_done);
  // R10
  tmo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_timeout |=> (wait_timeout && !rst_done && !op_valid));
endmodule

// File: tb/nand_bringup_seq_tb.sv
module nand_bringup_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY_CYC   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_noinit = 0, s_small = 0, s_noload = 0, s_two = 0;
  logic dev_ready = 1'b1;
  logic [15:0] wait_limit = 16'd200;
  logic op_valid, op_ready = 1'b0, op_is_addr;
  logic [7:0] op_byte;
  logic rd_valid = 1'b0, rd_ready;
  logic [7:0] rd_data = 8'h00;
  logic is_onfi, bus16, rst_done, wait_timeout;
  logic [31:0] page_bytes, ppb;
  logic [7:0] maker_id, device_id;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_bringup_seq dut_i (
    .clk(clk), .rst_n(rst_n), .strap_noinit(s_noinit), .strap_small_page(s_small),
    .strap_no_preload(s_noload), .strap_two_row(s_two), .dev_ready(dev_ready),
    .wait_limit(wait_limit), .op_valid(op_valid), .op_ready(op_ready),
    .op_is_addr(op_is_addr), .op_byte(op_byte), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .is_onfi(is_onfi), .bus16(bus16), .page_bytes(page_bytes),
    .pages_per_block(ppb), .maker_id(maker_id), .device_id(device_id),
    .rst_done(rst_done), .wait_timeout(wait_timeout)
  );

  int checks = 0, fails = 0;
  logic [8:0] expq[$];

  // PHY model state
  int  cyc = 0, busy_cnt = 0, rd_src = 0, rd_idx = 0;
  logic [7:0] last_cmd = 8'h00;
  logic onfi_dev = 1'b1, stuck = 1'b0;
  logic [7:0] leg_id [4];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pp_byte(int i);
    case (i)
      6:  return 8'h18;
      64: return 8'h2C;
      81: return 8'h10;
      80, 82, 83: return 8'h00;
      92: return 8'h80;
      93, 94, 95: return 8'h00;
      default: return 8'(i * 3 + 1);
    endcase
  endfunction

  function automatic logic [7:0] rd_byte(int src, int i);
    logic [7:0] sig [4] = '{8'h4F, 8'h4E, 8'h46, 8'h49};
    logic [7:0] bad [4] = '{8'hAD, 8'hDA, 8'h10, 8'h95};
    case (src)
      1: return onfi_dev ? sig[i % 4] : bad[i % 4];
      2: return leg_id[i % 4];
      3: return pp_byte(i);
      default: return 8'h00;
    endcase
  endfunction

  // PHY + scoreboard monitor, all at the falling edge
  always @(negedge clk) begin
    logic [8:0] got, exp;
    cyc++;
    if (!rst_n) begin
      busy_cnt = 0; rd_src = 0; rd_idx = 0;
      op_ready = 1'b0; rd_valid = 1'b0;
    end else begin
      if (busy_cnt > 0) busy_cnt--;
      op_ready = (cyc % 3) != 1;
      if (op_valid && op_ready) begin
        got = {op_is_addr, op_byte};
        checks++;
        if (busy_cnt > 0) begin
          fails++;
          $display("FAIL R9: op %h issued while busy, actual busy expected ready", got);
        end
        if (expq.size() == 0) begin
          fails++;
          $display("FAIL R11: unexpected op actual %h expected none", got);
        end else begin
          exp = expq.pop_front();
          if (got !== exp) begin
            fails++;
            $display("FAIL R3/R4/R7 order: actual %h expected %h", got, exp);
          end
        end
        if (!op_is_addr) begin
          last_cmd = op_byte;
          if (op_byte == 8'hFF || op_byte == 8'h30) busy_cnt = BUSY_CYC;
        end else if (last_cmd == 8'h90) begin
          rd_src = (op_byte == 8'h20) ? 1 : 2; rd_idx = 0;
        end else if (last_cmd == 8'hEC) begin
          rd_src = 3; rd_idx = 0; busy_cnt = BUSY_CYC;
        end
      end
      rd_valid = rd_ready && ((cyc % 4) != 2);
      rd_data  = rd_byte(rd_src, rd_idx);
      if (rd_valid) rd_idx++;
    end
    dev_ready = (busy_cnt == 0) && !stuck;
  end

  task automatic push(logic a, logic [7:0] b);
    expq.push_back({a, b});
  endtask

  task automatic push_tail(logic noload, logic two);
    push(0, 8'hFF);                                  // R6
    if (!noload) begin                               // R7
      push(0, 8'h00);
      repeat (two ? 4 : 5) push(1, 8'h00);
      push(0, 8'h30);
    end
    push(0, 8'hFF);                                  // R8
  endtask

  task automatic start(logic ni, logic sp, logic nl, logic tr);
    rst_n = 1'b0;
    expq.delete();
    s_noinit = ni; s_small = sp; s_noload = nl; s_two = tr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_wait(output int n);
    n = 0;
    while (!rst_done && !wait_timeout && n < 4000) begin
      @(negedge clk); n++;
    end
    repeat (12) @(negedge clk);
  endtask

  initial begin
    int n;
    leg_id = '{8'h2C, 8'hDA, 8'h90, 8'h55};

    // reset state
    repeat (2) @(negedge clk);
    chk("R8 reset rst_done", rst_done, 0);
    chk("R11 reset op_valid/rd_ready", {op_valid, rd_ready}, 0);
    chk("R2 reset params", page_bytes | ppb, 0);

    // ONFI device, three row cycles
    onfi_dev = 1; stuck = 0;
    start(0, 0, 0, 0);
    push(0, 8'h90); push(1, 8'h20); push(0, 8'hEC); push(1, 8'h00);
    push_tail(0, 0);
    finish_wait(n);
    chk("R3 is_onfi", is_onfi, 1);
    chk("R3 page_bytes", page_bytes, 4096);
    chk("R3 pages_per_block", ppb, 128);
    chk("R3 maker", maker_id, 8'h2C);
    chk("R6 bus16", bus16, 0);
    chk("R8 rst_done", {rst_done, wait_timeout}, 2'b10);
    chk("R7 all ops issued", expq.size(), 0);

    // legacy device via signature mismatch, two row cycles
    onfi_dev = 0;
    start(0, 0, 0, 1);
    push(0, 8'h90); push(1, 8'h20);
    push(0, 8'hFF); push(0, 8'h90); push(1, 8'h00);
    push_tail(0, 1);
    finish_wait(n);
    chk("R4 is_onfi", is_onfi, 0);
    chk("R4 maker/device", {maker_id, device_id}, 16'h2CDA);
    chk("R4 page_bytes", page_bytes, 2048);
    chk("R4 pages_per_block", ppb, 64);
    chk("R6 bus16 legacy", bus16, 1);
    chk("R8 rst_done legacy", rst_done, 1);
    chk("R7 all ops issued legacy", expq.size(), 0);

    // no-init strap
    start(1, 0, 0, 0);
    push(0, 8'hFF);
    finish_wait(n);
    chk("R2 rst_done", rst_done, 1);
    chk("R2 params untouched", page_bytes | ppb, 0);
    chk("R2 ids/flags untouched", {maker_id, device_id, bus16, is_onfi}, 0);
    chk("R2 only reset op", expq.size(), 0);

    // small-page strap with no preload
    leg_id = '{8'hEC, 8'h73, 8'h00, 8'h55};
    start(0, 1, 1, 0);
    push(0, 8'hFF); push(0, 8'h90); push(1, 8'h00);
    push_tail(1, 0);
    finish_wait(n);
    chk("R5 page_bytes", page_bytes, 512);
    chk("R5 pages_per_block", ppb, 32);
    chk("R5 maker/device", {maker_id, device_id}, 16'hEC73);
    chk("R5 bus16 forced", bus16, 0);
    chk("R7 no preload ops", expq.size(), 0);

    // straps changed after release are ignored
    onfi_dev = 1;
    start(0, 0, 0, 0);
    push(0, 8'h90); push(1, 8'h20); push(0, 8'hEC); push(1, 8'h00);
    push_tail(0, 0);
    repeat (3) @(negedge clk);
    s_noinit = 1; s_small = 1; s_noload = 1; s_two = 1;
    finish_wait(n);
    chk("R1 late straps ignored", expq.size(), 0);
    chk("R1 done with onfi", {rst_done, is_onfi}, 2'b11);

    // device never ready
    stuck = 1; wait_limit = 16'd40;
    start(0, 0, 0, 0);
    finish_wait(n);
    chk("R10 timeout flag", {wait_timeout, rst_done}, 2'b10);
    chk("R10 not before limit", (n >= 40), 1);
    chk("R10 no ops", expq.size(), 0);
    stuck = 0;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule